// File: doc/BRIEF.md
# Address filter table load sequencer

This block is a bus master that fills a table of station addresses from a descriptor list in system memory. The host writes a start pulse along with the entry count, the low half of the list pointer, the upper address half and the data-width mode. The block then walks the list one entry at a time. Each entry is four 16-bit words. The first word names the table slot and the next three words carry the 48-bit address. All reads go through a simple request/response port that allows only one read in flight.

When the count reaches zero, the block reads one more word at the current pointer. It keeps that word as the per-slot enable mask, drops its busy indication and raises a sticky done flag. Software clears the flag with a pulse. Table contents can be read back through a slot selector, but only while the controller is held in software reset.

Top module: `cam_load_seq`

## Requirements
- R1: After reset, busy, done_flag, enable_mask, mem_req_valid, cur_cnt and cur_ptr_lo are all zero.
- R2: Word n of an entry is requested at the 32-bit sum {ptr_hi, current low pointer} + 2n in narrow mode (wide_mode=0), or + 4n in wide mode (wide_mode=1). Words are requested in the order 0, 1, 2, 3.
- R3: While a request is not accepted, mem_req_valid stays high and mem_req_addr stays stable. After a request is accepted, no new request is issued until its response has arrived.
- R4: Bits [3:0] of word 0 select the slot. Words 1, 2 and 3 are stored as parts 1, 2 and 3 of that slot. Only bits [15:0] of each response are kept, in both modes.
- R5: After each entry, cur_cnt decrements by one. cur_ptr_lo advances by 8 in narrow mode or by 16 in wide mode, and wraps modulo 2^16 without touching ptr_hi.
- R6: Once the count is zero, one further word is read at the current pointer (offset 0), and its low 16 bits become enable_mask.
- R7: When the mask response is taken, busy falls and done_flag rises in the same cycle. done_flag then stays set until a done_clr pulse.
- R8: A start with count 0 issues exactly one read, for the mask at ptr_lo_in, and then completes.
- R9: cam_part1..3 return the selected slot's parts while sw_reset is 1, and read as zero while sw_reset is 0.
- R10: A start pulse that arrives while busy is ignored. The running load finishes with its original count, pointer and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Load command pulse |
| wide_mode | input | 1 | 1 selects 32-bit data mode |
| count_in | input | CNT_W | Number of entries to load |
| ptr_lo_in | input | 16 | Initial low half of list pointer |
| ptr_hi_in | input | 16 | Upper 16 address bits |
| done_clr | input | 1 | Clears done_flag |
| sw_reset | input | 1 | Software reset hold; gates readback |
| cam_sel | input | IDX_W | Slot selected for readback |
| busy | output | 1 | Load command in progress |
| done_flag | output | 1 | Load-done status |
| cur_cnt | output | CNT_W | Remaining entry count |
| cur_ptr_lo | output | 16 | Current low pointer |
| enable_mask | output | 16 | Per-slot enable mask |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| cam_part1 | output | 16 | Selected slot, part 1 |
| cam_part2 | output | 16 | Selected slot, part 2 |
| cam_part3 | output | 16 | Selected slot, part 3 |

## Verification
The bench uses the default parameters: 16 slots, a 5-bit count and a 32-bit response bus. The 32-bit bus puts random upper halves on the data port, so the bench can check that only the low 16 bits are kept in both modes. With counts up to 31, a single load writes many slots, repeats some of them so that the last write wins, and drives the low pointer across its 16-bit wrap. Random acceptance and response latency exercise the one-in-flight handshake.

// File: rtl/cam_load_seq.sv
module cam_load_seq #(
  parameter int SLOTS = 16,
  parameter int CNT_W = 5,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     wide_mode,
  input  logic [CNT_W-1:0]         count_in,
  input  logic [15:0]              ptr_lo_in,
  input  logic [15:0]              ptr_hi_in,
  input  logic                     done_clr,
  input  logic                     sw_reset,
  input  logic [$clog2(SLOTS)-1:0] cam_sel,
  output logic                     busy,
  output logic                     done_flag,
  output logic [CNT_W-1:0]         cur_cnt,
  output logic [15:0]              cur_ptr_lo,
  output logic [15:0]              enable_mask,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [31:0]              mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [DW-1:0]            mem_rsp_data,
  output logic [15:0]              cam_part1,
  output logic [15:0]              cam_part2,
  output logic [15:0]              cam_part3
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [15:0] tbl1 [SLOTS];
  logic [15:0] tbl2 [SLOTS];
  logic [15:0] tbl3 [SLOTS];
  logic [15:0] hi_q;
  logic        wide_q, waiting, mask_phase;
  logic [1:0]  word;
  logic [IDX_W-1:0] slot;
  logic [3:0]  offset;
  logic [15:0] stride, rsp_lo;

  assign offset        = wide_q ? {word, 2'b00} : {1'b0, word, 1'b0};
  assign stride        = wide_q ? 16'd16 : 16'd8;
  assign rsp_lo        = mem_rsp_data[15:0];
  assign mem_req_valid = busy && !waiting;
  assign mem_req_addr  = {hi_q, cur_ptr_lo} + {28'd0, offset};
  assign cam_part1     = sw_reset ? tbl1[cam_sel] : 16'd0;
  assign cam_part2     = sw_reset ? tbl2[cam_sel] : 16'd0;
  assign cam_part3     = sw_reset ? tbl3[cam_sel] : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done_flag   <= 1'b0;
      cur_cnt     <= '0;
      cur_ptr_lo  <= '0;
      enable_mask <= '0;
      hi_q        <= '0;
      wide_q      <= 1'b0;
      waiting     <= 1'b0;
      mask_phase  <= 1'b0;
      word        <= '0;
      slot        <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        tbl1[i] <= '0;
        tbl2[i] <= '0;
        tbl3[i] <= '0;
      end
    end else begin
      if (done_clr) done_flag <= 1'b0;
      if (start && !busy) begin
        busy       <= 1'b1;
        cur_cnt    <= count_in;
        cur_ptr_lo <= ptr_lo_in;
        hi_q       <= ptr_hi_in;
        wide_q     <= wide_mode;
        word       <= '0;
        waiting    <= 1'b0;
        mask_phase <= (count_in == '0);
      end else if (busy) begin
        if (mem_req_valid && mem_req_ready) waiting <= 1'b1;
        if (waiting && mem_rsp_valid) begin
          waiting <= 1'b0;
          if (mask_phase) begin
            enable_mask <= rsp_lo;
            busy        <= 1'b0;
            done_flag   <= 1'b1;
          end else begin
            case (word)
              2'd0: slot <= rsp_lo[IDX_W-1:0];
              2'd1: tbl1[slot] <= rsp_lo;
              2'd2: tbl2[slot] <= rsp_lo;
              default: tbl3[slot] <= rsp_lo;
            endcase
            word <= word + 2'd1;
            if (word == 2'd3) begin
              cur_cnt    <= cur_cnt - 1'b1;
              cur_ptr_lo <= cur_ptr_lo + stride;
              mask_phase <= (cur_cnt == CNT_W'(1));
            end
          end
        end
      end
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_inflight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (cur_cnt != $past(cur_cnt)) |-> cur_cnt == $past(cur_cnt) - 1'b1);

  assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag && $past(mem_rsp_valid));

endmodule

// File: tb/test_cam_load_seq.sv
module test_cam_load_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, wide_mode = 0, done_clr = 0, sw_reset = 0;
  logic [4:0] count_in = 0;
  logic [15:0] ptr_lo_in = 0, ptr_hi_in = 0;
  logic [3:0] cam_sel = 0;
  logic busy, done_flag, mem_req_valid;
  logic [4:0] cur_cnt;
  logic [15:0] cur_ptr_lo, enable_mask, cam_part1, cam_part2, cam_part3;
  logic [31:0] mem_req_addr;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] log_addr [256];
  int n_log = 0;
  bit pend = 0;
  int lat = 0;
  logic [31:0] pend_addr;
  logic [15:0] m1 [16], m2 [16], m3 [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_load_seq i_cam_load_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .count_in(count_in), .ptr_lo_in(ptr_lo_in), .ptr_hi_in(ptr_hi_in),
    .done_clr(done_clr), .sw_reset(sw_reset), .cam_sel(cam_sel),
    .busy(busy), .done_flag(done_flag), .cur_cnt(cur_cnt), .cur_ptr_lo(cur_ptr_lo),
    .enable_mask(enable_mask), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cam_part1(cam_part1), .cam_part2(cam_part2), .cam_part3(cam_part3));

  function automatic logic [31:0] data_at(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]} ^ 32'h5A5A1234;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = data_at(pend_addr);
          pend = 0;
        end else lat--;
      end
      mem_req_ready = ($urandom_range(0, 2) != 0);
      if (mem_req_valid && mem_req_ready) begin
        if (n_log < 256) log_addr[n_log] = mem_req_addr;
        n_log++;
        pend = 1;
        pend_addr = mem_req_addr;
        lat = $urandom_range(0, 2);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_load(int cnt, logic [15:0] lo, logic [15:0] hi, bit wide, bit disturb);
    logic [31:0] base;
    logic [15:0] lo_e, w0;
    int step, k;
    @(negedge clk);
    n_log = 0;
    count_in = cnt[4:0]; ptr_lo_in = lo; ptr_hi_in = hi; wide_mode = wide; start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      count_in = 5'd7; ptr_lo_in = 16'h1230; ptr_hi_in = 16'h4444; wide_mode = ~wide; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    step = wide ? 4 : 2;
    lo_e = lo;
    k = 0;
    chk(n_log == cnt * 4 + 1, cnt == 0 ? "R8 read count" : "R3 R10 read count", n_log, cnt * 4 + 1);
    for (int e = 0; e < cnt; e++) begin
      base = {hi, lo_e};
      for (int w = 0; w < 4; w++) begin
        chk(log_addr[k] == base + w * step, "R2 word address", log_addr[k], base + w * step);
        k++;
      end
      w0 = data_at(base)[15:0];
      m1[w0[3:0]] = data_at(base + step)[15:0];
      m2[w0[3:0]] = data_at(base + 2 * step)[15:0];
      m3[w0[3:0]] = data_at(base + 3 * step)[15:0];
      lo_e = lo_e + (wide ? 16'd16 : 16'd8);
    end
    base = {hi, lo_e};
    chk(log_addr[k] == base, "R6 mask address", log_addr[k], base);
    chk(enable_mask == data_at(base)[15:0], "R6 mask value", enable_mask, data_at(base)[15:0]);
    chk(cur_cnt == 0, "R5 final count", cur_cnt, 0);
    chk(cur_ptr_lo == lo_e, "R5 pointer advance", cur_ptr_lo, lo_e);
    chk(done_flag == 1, "R7 done set", done_flag, 1);
    done_clr = 1;
    @(negedge clk);
    done_clr = 0;
    chk(done_flag == 0, "R7 done cleared", done_flag, 0);
    sw_reset = 1;
    for (int s = 0; s < 16; s++) begin
      cam_sel = s[3:0];
      #1;
      chk(cam_part1 == m1[s], "R4 part1", cam_part1, m1[s]);
      chk(cam_part2 == m2[s], "R4 part2", cam_part2, m2[s]);
      chk(cam_part3 == m3[s], "R4 part3", cam_part3, m3[s]);
      chk(cam_part1 == m1[s] && cam_part3 == m3[s], "R9 readback in reset", cam_part1, m1[s]);
    end
    sw_reset = 0;
    #1;
    chk(cam_part1 == 0 && cam_part2 == 0 && cam_part3 == 0, "R9 readback gated", cam_part1, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 16; s++) begin m1[s] = 0; m2[s] = 0; m3[s] = 0; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done_flag == 0 && mem_req_valid == 0, "R1 reset control", {busy, done_flag, mem_req_valid}, 0);
    chk(enable_mask == 0 && cur_cnt == 0 && cur_ptr_lo == 0, "R1 reset state", enable_mask, 0);
    rst_n = 1;
    run_load(3, 16'h0100, 16'h8000, 0, 0);
    run_load(2, 16'h0200, 16'h8001, 1, 0);
    run_load(0, 16'h0ABC, 16'h1234, 0, 0);
    run_load(2, 16'hFFF8, 16'h2000, 0, 0);
    run_load(2, 16'hFFF0, 16'h2001, 1, 0);
    run_load(4, 16'h0400, 16'h3000, 0, 1);
    run_load(31, 16'hFF00, 16'h5000, 1, 0);
    for (int r = 0; r < 6; r++)
      run_load($urandom_range(0, 31), 16'($urandom) & 16'hFFFC, 16'($urandom), $urandom_range(0, 1), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule